// File: doc/BRIEF.md
# RAM-backed tapped delay line

This block is a long delay line for streams of data words. It does not use one long chain of flip-flops. Each segment of the line keeps its words in a small memory that works as a circular buffer. All segments share one rotating pointer. Each enabled clock edge does two things at the pointer's address in every segment: it reads out the oldest word and writes in the newest one. The line is made of a parameterised number of equal segments. Each segment adds the same number of cycles of delay. Every segment has a registered output, and these outputs form a set of equally spaced tap outputs that are all visible at the same time.

The far end of the line can also drive a cascade output, so that a second instance can continue the line. A clock-enable input can be built in to stop the whole line. When the enable is low, every tap holds its value, and the line later carries on as if the disabled cycles had never happened.

A segment in memory only pays off when the spacing is at least 3. For spacing 1 or 2 the block builds the segment from registers instead, with the same timing at the ports.

The taps are not defined until the line has filled. The sections below call them unknown during that time. They are not unknown just after reset; see R5.

Top module: `tap_delay_line`

## Requirements
- R1: Tap k (k = 0 .. NTAPS-1) appears on `taps_o[k*WIDTH +: WIDTH]`. After any enabled edge, tap k holds the same value as stage (k+1)·SPACING of a flip-flop chain clocked by the same enables. That value is the word sampled on `din_i` at the enabled edge that came (k+1)·SPACING−1 enabled edges before the latest one, where the latest enabled edge counts as zero edges before itself. Tap 0 is the least delayed tap.
- R2: When HAS_SHIFT_OUT is 1, `shout_o` equals the last tap, which is the input delayed by NTAPS·SPACING stages. When HAS_SHIFT_OUT is 0, `shout_o` is constant zero.
- R3: When HAS_ENABLE is 1 and `en_i` is low at a clock edge, no tap and no shift-out changes, and the word on `din_i` at that edge is dropped. Later outputs follow the sequence of enabled edges only.
- R4: When HAS_ENABLE is 0, `en_i` is ignored and the line shifts on every clock edge.
- R5: While `rst_n` is low, every tap and `shout_o` become zero at the next edge, and the shared pointer returns to address 0.
- R6: For SPACING ≥ 3, each segment is a memory of SPACING−1 words followed by an output register. For SPACING 1 or 2, each segment is a chain of SPACING registers. At the ports, both forms have the R1 timing.
- R7: The shared pointer moves by one only on enabled edges. After address SPACING−2 it wraps to 0.
- R8: All segments advance together. Segment k+1 takes its input from the registered output of segment k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; active on the rising edge |
| rst_n | input | 1 | Reset, active low, synchronous |
| en_i | input | 1 | Enable for the whole line; used only when HAS_ENABLE is 1 |
| din_i | input | WIDTH | Data word that enters the line |
| taps_o | output | NTAPS*WIDTH | All tap outputs side by side; tap k is at bits k*WIDTH upward |
| shout_o | output | WIDTH | Cascade output from the far end of the line |

## Verification
Every output is registered, so all results of a given enabled edge appear right after that edge. The bench drives inputs on the falling edge and checks them on the next falling edge. For each instance it keeps its own count of enabled edges. From that count it computes, by arithmetic, the sample index each tap should show: the count minus (k+1)·SPACING, plus one. Before that index reaches 1, the tap is still filling and is not checked. Cycles with the enable low leave the count unchanged, so the bench expects the outputs to hold. Three instances are checked: one with memory segments, one with register segments, and one with no enable and no shift-out.

// File: rtl/tdl_pkg.sv
package tdl_pkg;

    // Smallest tap spacing for which a segment is built as a memory.
    localparam int unsigned MIN_RAM_SPACING = 3;

    // Chooses how a segment is built.
    function automatic bit seg_uses_ram(input int unsigned spacing);
        return spacing >= MIN_RAM_SPACING;
    endfunction

    // Width of a pointer that counts through 'depth' words; never less than 1.
    function automatic int unsigned ptr_width(input int unsigned depth);
        return (depth > 1) ? $clog2(depth) : 1;
    endfunction

endpackage

// File: rtl/tdl_ptr.sv
module tdl_ptr #(
    parameter int unsigned DEPTH = 4,
    localparam int unsigned PW   = tdl_pkg::ptr_width(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    output logic [PW-1:0] ptr_o
);

    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_o <= '0;
        end else if (en) begin
            ptr_o <= (ptr_o == LAST) ? '0 : ptr_o + 1'b1;
        end
    end

    // R7: the pointer never leaves the memory's address range
    a_r7_ptr_range: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_o <= LAST);
    // R7: the pointer wraps from the last address to 0
    a_r7_ptr_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (en && ptr_o == LAST) |=> ptr_o == '0);
    // R7: below the last address the pointer steps up by one
    a_r7_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (en && ptr_o != LAST) |=> ptr_o == $past(ptr_o) + 1'b1);
    // R3: a disabled edge leaves the pointer where it is
    a_r3_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(ptr_o));
    // R5: reset puts the pointer at address 0
    a_r5_ptr_reset: assert property (@(posedge clk)
        !rst_n |=> ptr_o == '0);

endmodule

// File: rtl/tdl_seg_ram.sv
module tdl_seg_ram #(
    parameter int unsigned WIDTH = 8,
    parameter int unsigned DEPTH = 4,
    localparam int unsigned PW   = tdl_pkg::ptr_width(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [PW-1:0]    ptr,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] mem [DEPTH];

    // Write port. The memory array has no reset.
    always_ff @(posedge clk) begin
        if (en) begin
            mem[ptr] <= d;
        end
    end

    // The read at the same address gets the word stored DEPTH enabled edges ago.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (en) begin
            q <= mem[ptr];
        end
    end

    // R3: a disabled edge leaves the segment output unchanged
    a_r3_ram_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(q));
    // R5: reset clears the segment output
    a_r5_ram_reset: assert property (@(posedge clk)
        !rst_n |=> q == '0);

endmodule

// File: rtl/tdl_seg_reg.sv
module tdl_seg_reg #(
    parameter int unsigned WIDTH = 8,
    parameter int unsigned DEPTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] stage [DEPTH];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < int'(DEPTH); i++) begin
                stage[i] <= '0;
            end
        end else if (en) begin
            stage[0] <= d;
            for (int i = 1; i < int'(DEPTH); i++) begin
                stage[i] <= stage[i-1];
            end
        end
    end

    assign q = stage[DEPTH-1];

    // R3: a disabled edge leaves the register segment unchanged
    a_r3_reg_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(q));
    // R5: reset clears the register segment
    a_r5_reg_reset: assert property (@(posedge clk)
        !rst_n |=> q == '0);

endmodule

// File: rtl/tap_delay_line.sv
module tap_delay_line #(
    parameter int unsigned WIDTH         = 8,
    parameter int unsigned NTAPS         = 4,
    parameter int unsigned SPACING       = 5,
    parameter bit          HAS_ENABLE    = 1'b1,
    parameter bit          HAS_SHIFT_OUT = 1'b1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   en_i,
    input  logic [WIDTH-1:0]       din_i,
    output logic [NTAPS*WIDTH-1:0] taps_o,
    output logic [WIDTH-1:0]       shout_o
);

    localparam bit          USE_RAM   = tdl_pkg::seg_uses_ram(SPACING);
    localparam int unsigned RAM_DEPTH = USE_RAM ? SPACING - 1 : 2;
    localparam int unsigned PW        = tdl_pkg::ptr_width(RAM_DEPTH);

    logic             en_int;
    logic [WIDTH-1:0] seg_d [NTAPS];
    logic [WIDTH-1:0] seg_q [NTAPS];

    // R4: with no enable port, the line shifts on every clock edge
    assign en_int = HAS_ENABLE ? en_i : 1'b1;

    // R8: each segment takes its input from the previous segment's registered output
    assign seg_d[0] = din_i;
    for (genvar k = 1; k < NTAPS; k++) begin : g_link
        assign seg_d[k] = seg_q[k-1];
    end

    if (USE_RAM) begin : g_ram
        logic [PW-1:0] ptr;

        tdl_ptr #(.DEPTH(RAM_DEPTH)) i_ptr (
            .clk   (clk),
            .rst_n (rst_n),
            .en    (en_int),
            .ptr_o (ptr)
        );

        for (genvar k = 0; k < NTAPS; k++) begin : g_seg
            tdl_seg_ram #(.WIDTH(WIDTH), .DEPTH(RAM_DEPTH)) i_seg (
                .clk   (clk),
                .rst_n (rst_n),
                .en    (en_int),
                .ptr   (ptr),
                .d     (seg_d[k]),
                .q     (seg_q[k])
            );
        end
    end else begin : g_reg
        for (genvar k = 0; k < NTAPS; k++) begin : g_seg
            tdl_seg_reg #(.WIDTH(WIDTH), .DEPTH(SPACING)) i_seg (
                .clk   (clk),
                .rst_n (rst_n),
                .en    (en_int),
                .d     (seg_d[k]),
                .q     (seg_q[k])
            );
        end
    end

    for (genvar k = 0; k < NTAPS; k++) begin : g_tap
        assign taps_o[k*WIDTH +: WIDTH] = seg_q[k];
    end

    // R2: the cascade output is the far end of the line, or zero when it is not built
    assign shout_o = HAS_SHIFT_OUT ? seg_q[NTAPS-1] : '0;

    // R3: a disabled edge changes no tap
    a_r3_taps_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !en_int |=> $stable(taps_o));
    // R8: on an enabled edge, tap 1 takes the value tap 0 held SPACING-1 enabled edges
    // earlier; this check covers spacing 1, where that means the value just before the edge
    a_r8_lockstep: assert property (@(posedge clk) disable iff (!rst_n)
        (SPACING == 1 && NTAPS > 1 && en_int && $past(rst_n))
        |=> taps_o[2*WIDTH-1 -: WIDTH] == $past(taps_o[WIDTH-1:0]));

endmodule

// File: tb/test_tap_delay_line.sv
module test_tap_delay_line;

    localparam int W  = 8;
    localparam int NA = 4, SA = 5;   // memory segments
    localparam int NB = 3, SB = 2;   // register segments
    localparam int NC = 2, SC = 3;   // no enable, no shift-out

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b0;
    logic [W-1:0] din = '0;
    logic [W-1:0] din_c = '0;
    logic [NA*W-1:0] taps_a;
    logic [NB*W-1:0] taps_b;
    logic [NC*W-1:0] taps_c;
    logic [W-1:0] sh_a, sh_b, sh_c;

    int checks = 0;
    int fails  = 0;
    int cnt_ab = 0;
    int cnt_c  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;   // 200 MHz

    tap_delay_line #(.WIDTH(W), .NTAPS(NA), .SPACING(SA)) i_tap_delay_line (
        .clk(clk), .rst_n(rst_n), .en_i(en), .din_i(din), .taps_o(taps_a), .shout_o(sh_a));

    tap_delay_line #(.WIDTH(W), .NTAPS(NB), .SPACING(SB)) i_tap_delay_line_reg (
        .clk(clk), .rst_n(rst_n), .en_i(en), .din_i(din), .taps_o(taps_b), .shout_o(sh_b));

    tap_delay_line #(.WIDTH(W), .NTAPS(NC), .SPACING(SC), .HAS_ENABLE(1'b0),
                     .HAS_SHIFT_OUT(1'b0)) i_tap_delay_line_noen (
        .clk(clk), .rst_n(rst_n), .en_i(en), .din_i(din_c), .taps_o(taps_c), .shout_o(sh_c));

    function automatic logic [W-1:0] word_ab(input int j);
        return W'((j * 37 + 11) % 256);
    endfunction

    function automatic logic [W-1:0] word_c(input int j);
        return W'((j * 53 + 200) % 256);
    endfunction

    task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Tap k after enabled edge number cnt carries the sample from edge cnt-(k+1)*s+1.
    task automatic check_line(input string tag, input int n, input int s, input int cnt,
                              input logic [63:0] flat, input bit is_c);
        for (int k = 0; k < n; k++) begin
            if (cnt >= (k + 1) * s) begin
                int j = cnt - (k + 1) * s + 1;
                check(tag, flat[k*W +: W], is_c ? word_c(j) : word_ab(j));
            end
        end
    endtask

    // One clock: drive on the falling edge, let the rising edge act, check on the next falling edge.
    task automatic step(input bit e, input int cyc);
        en    = e;
        din   = e ? word_ab(cnt_ab + 1) : W'(8'hA5 ^ cyc);
        din_c = word_c(cnt_c + 1);
        @(posedge clk);
        if (e) cnt_ab++;
        cnt_c++;
        @(negedge clk);
        check_line(e ? "R1 mem taps" : "R3 mem hold", NA, SA, cnt_ab, 64'(taps_a), 1'b0);
        check_line(e ? "R6 reg taps" : "R3 reg hold", NB, SB, cnt_ab, 64'(taps_b), 1'b0);
        check_line("R4 no-enable taps", NC, SC, cnt_c, 64'(taps_c), 1'b1);
        if (cnt_ab >= NA * SA)
            check("R2 mem shout", sh_a, word_ab(cnt_ab - NA * SA + 1));
        if (cnt_ab >= NB * SB)
            check("R2 reg shout", sh_b, word_ab(cnt_ab - NB * SB + 1));
        check("R2 shout off", sh_c, '0);
    endtask

    initial begin
        en = 1'b1;
        din = 8'h5A;
        din_c = 8'h3C;
        repeat (4) @(posedge clk);
        @(negedge clk);
        // R5: reset state
        for (int k = 0; k < NA; k++) check("R5 reset tap", taps_a[k*W +: W], '0);
        for (int k = 0; k < NB; k++) check("R5 reset tap", taps_b[k*W +: W], '0);
        for (int k = 0; k < NC; k++) check("R5 reset tap", taps_c[k*W +: W], '0);
        check("R5 reset shout", sh_a, '0);
        rst_n = 1'b1;
        // R1/R7/R8: continuous enable, many pointer wraps
        for (int c = 0; c < 60; c++) step(1'b1, c);
        // R3: alternating enable
        for (int c = 0; c < 80; c++) step(c[0], c);
        // R3: irregular bursts of disabled edges
        for (int c = 0; c < 200; c++) step(((c * 7) % 5) != 0 && ((c / 11) % 3) != 1, c);
        // R3: a long stall, then a restart
        for (int c = 0; c < 25; c++) step(1'b0, c);
        for (int c = 0; c < 40; c++) step(1'b1, c);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

endmodule